// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the control strobes and the multiplexed address/data lines of an 8-bit external memory bus. Time is split into machine cycles of twelve clocks, counted by an internal phase counter. At the start of each machine cycle (phase 0) the block samples what the cycle does: an opcode fetch, a code-table read, an external data read or an external data write. It also samples the execution-mode flag, the latch-strobe disable bit and the addressing mode. From then on it plays a fixed timing pattern on the address-latch strobe (`ale_o`), the active-low program-store read strobe (`psen_no`), the data read strobe (`rd_no`) and the data write strobe (`wr_no`).

The low byte of the address is driven on `ad_o` with `ad_oe_o` high while the latch strobe is high. The bus is released before any read strobe falls. In a write cycle the write data takes the bus around the write strobe. The high address byte on `addr_hi_o` is the program address, the data-pointer high byte or the port-2 latch value, depending on the access. The block does no instruction decoding and has no datapath. Every output is registered.

Top module: `xbus_strobe`

## Requirements
- R1: In a cycle that is not a data access, `ale_o` is high in phases 0-1 and 6-7 and low in every other phase, unless R5 applies. That gives two pulses per machine cycle, each two clocks wide.
- R2: In a cycle that is not a data access, `psen_no` is low in phases 3-5 and 9-11 when the external-execution flag or the code-read request is set. Each low pulse starts one clock after `ale_o` falls. Otherwise `psen_no` stays high.
- R3: In a data-access cycle, `ale_o` pulses only in phases 0-1, so the second pulse is dropped. `psen_no` stays high for all twelve phases.
- R4: In a data read cycle, `rd_no` is low in phases 5-10. In a data write cycle, `wr_no` is low in phases 5-10. If both requests are set, the cycle is a write. `rd_no` and `wr_no` are never low together.
- R5: When the disable bit is set and the cycle is neither a data access nor a code read, and the external-execution flag is clear, `ale_o` stays high for the whole cycle.
- R6: The disable bit has no effect when the external-execution flag is set, or in data-access and code-read cycles. In those cases `ale_o` follows R1 or R3.
- R7: In data-access cycles, `addr_hi_o` is the data-pointer high byte when `ind8_i`=0 and the port-2 latch when `ind8_i`=1. In other cycles it is `pc_i[15:8]`.
- R8: The bus is driven only in cycles with external activity (external execution, a code read or a data access). In such a cycle, `ad_oe_o` is high with the low address on `ad_o` during phases 0-1. In non-data cycles it is also high during phases 6-7. The low address is `pc_i[7:0]`, or in data cycles `dptr_i[7:0]` (`ind8_i`=0) or `ri_addr_i` (`ind8_i`=1). `ad_oe_o` is never high while `psen_no` or `rd_no` is low.
- R9: In a write cycle, `ad_o` carries `wr_data_i` with `ad_oe_o` high in phases 3-11. That is two clocks before `wr_no` falls and one clock after it rises.
- R10: While `rst_ni` is low: `ale_o`=0, `psen_no`=`rd_no`=`wr_no`=1, `ad_oe_o`=0, `ad_o`=0 and `addr_hi_o`=0. The first clock edge after release outputs phase 0.
- R11: Request and mode inputs are sampled only at phase 0. A request raised later in the cycle has no effect on that cycle's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_exec_i | input | 1 | Code is fetched from external memory |
| ale_dis_i | input | 1 | Latch-strobe disable bit |
| xrd_req_i | input | 1 | External data read this cycle |
| xwr_req_i | input | 1 | External data write this cycle |
| code_rd_i | input | 1 | Code-table read this cycle |
| ind8_i | input | 1 | Data access uses 8-bit indirect address |
| pc_i | input | 16 | Program address |
| dptr_i | input | 16 | Data pointer |
| ri_addr_i | input | 8 | 8-bit indirect address |
| p2_latch_i | input | 8 | Port-2 latch value |
| wr_data_i | input | 8 | Write data |
| ale_o | output | 1 | Address-latch strobe |
| psen_no | output | 1 | Program-store read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Low address / data byte |
| ad_oe_o | output | 1 | Low bus output enable |
| addr_hi_o | output | 8 | High address byte |

## Verification
The assertions check, on every cycle, the rules that never depend on the kind of cycle:
- read and write strobes are never low together;
- the program strobe never overlaps a data strobe;
- the bus is released whenever a read strobe is low;
- the bus is driven all through a write strobe and for the clock after it;
- each strobe falls only after the latch strobe has been low for the required number of clocks.

Only the bench's sweep can show the exact phase placement of every pulse for each combination of execution mode, disable bit, request and addressing mode. The same holds for the byte chosen for each address half, and for the fact that a request raised after phase 0 is ignored.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;
  typedef enum logic [1:0] {CYC_FETCH, CYC_CODE, CYC_RD, CYC_WR} cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      ind8;
    logic      ale_en;
    logic      fetch_en;
    logic      active;
  } cyc_cfg_t;

  typedef enum logic [1:0] {SRC_NONE, SRC_ADDR, SRC_WDATA} bus_src_e;

  typedef struct packed {
    logic     ale;
    logic     psen_n;
    logic     rd_n;
    logic     wr_n;
    bus_src_e src;
  } strobe_t;

  function automatic logic is_data(cyc_kind_e k);
    return (k == CYC_RD) || (k == CYC_WR);
  endfunction
endpackage

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
  parameter int CYC_LEN = 12,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o,
  output logic          start_o
);
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_o <= '0;
    else if (phase_o == LAST)  phase_o <= '0;
    else                       phase_o <= phase_o + 1'b1;
  end

  assign start_o = (phase_o == '0);
endmodule

// File: rtl/xbus_cyc_class.sv
module xbus_cyc_class
  import xbus_strobe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     ext_exec_i,
  input  logic     ale_dis_i,
  input  logic     xrd_req_i,
  input  logic     xwr_req_i,
  input  logic     code_rd_i,
  input  logic     ind8_i,
  output cyc_cfg_t cfg_o
);
  cyc_cfg_t live, held;

  always_comb begin
    live.ind8 = ind8_i;
    if (xwr_req_i)      live.kind = CYC_WR;   // write wins over read
    else if (xrd_req_i) live.kind = CYC_RD;
    else if (code_rd_i) live.kind = CYC_CODE;
    else                live.kind = CYC_FETCH;
    live.fetch_en = ext_exec_i || (live.kind == CYC_CODE);
    live.ale_en   = !ale_dis_i || ext_exec_i || (live.kind != CYC_FETCH);
    live.active   = live.fetch_en || is_data(live.kind);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held <= '{kind: CYC_FETCH, ind8: 1'b0, ale_en: 1'b1, fetch_en: 1'b0, active: 1'b0};
    else if (start_i) held <= live;
  end

  assign cfg_o = start_i ? live : held;
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_strobe_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3,
  parameter int STB_W   = 6,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic [PW-1:0] phase_i,
  input  cyc_cfg_t      cfg_i,
  output strobe_t       stb_o
);
  localparam int HALF   = CYC_LEN / 2;
  localparam int PSEN_0 = ALE_W + 1;          // one clock after latch falls
  localparam int STB_0  = ALE_W + 3;          // three clocks after latch falls
  localparam int WD_0   = ALE_W + 1;
  localparam int WD_N   = STB_0 + STB_W + 1 - WD_0;

  function automatic logic in_win(int p, int lo, int n);
    return (p >= lo) && (p < lo + n);
  endfunction

  int  p;
  logic first_ale, second_ale, data;

  always_comb begin
    p          = int'(phase_i);
    data       = is_data(cfg_i.kind);
    first_ale  = in_win(p, 0, ALE_W);
    second_ale = in_win(p, HALF, ALE_W);

    stb_o.ale = !cfg_i.ale_en || first_ale || (second_ale && !data);

    stb_o.psen_n = !(cfg_i.fetch_en && !data &&
                     (in_win(p, PSEN_0, PSEN_W) || in_win(p, HALF + PSEN_0, PSEN_W)));
    stb_o.rd_n = !((cfg_i.kind == CYC_RD) && in_win(p, STB_0, STB_W));
    stb_o.wr_n = !((cfg_i.kind == CYC_WR) && in_win(p, STB_0, STB_W));

    stb_o.src = SRC_NONE;
    if (cfg_i.active) begin
      if (first_ale || (second_ale && !data))                  stb_o.src = SRC_ADDR;
      else if (cfg_i.kind == CYC_WR && in_win(p, WD_0, WD_N))  stb_o.src = SRC_WDATA;
    end
  end
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
  import xbus_strobe_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3,
  parameter int STB_W   = 6,
  parameter int BW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_exec_i,
  input  logic          ale_dis_i,
  input  logic          xrd_req_i,
  input  logic          xwr_req_i,
  input  logic          code_rd_i,
  input  logic          ind8_i,
  input  logic [2*BW-1:0] pc_i,
  input  logic [2*BW-1:0] dptr_i,
  input  logic [BW-1:0] ri_addr_i,
  input  logic [BW-1:0] p2_latch_i,
  input  logic [BW-1:0] wr_data_i,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic [BW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] addr_hi_o
);
  localparam int PW = $clog2(CYC_LEN);

  logic [PW-1:0] phase;
  logic          start;
  cyc_cfg_t      cfg;
  strobe_t       stb;
  logic [BW-1:0] lo_sel, hi_sel, ad_nxt;

  xbus_phase_cnt #(.CYC_LEN(CYC_LEN)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase), .start_o(start)
  );

  xbus_cyc_class u_class (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .ext_exec_i(ext_exec_i), .ale_dis_i(ale_dis_i),
    .xrd_req_i(xrd_req_i), .xwr_req_i(xwr_req_i), .code_rd_i(code_rd_i),
    .ind8_i(ind8_i), .cfg_o(cfg)
  );

  xbus_strobe_dec #(
    .CYC_LEN(CYC_LEN), .ALE_W(ALE_W), .PSEN_W(PSEN_W), .STB_W(STB_W)
  ) u_dec (
    .phase_i(phase), .cfg_i(cfg), .stb_o(stb)
  );

  always_comb begin
    if (is_data(cfg.kind)) begin
      lo_sel = cfg.ind8 ? ri_addr_i  : dptr_i[BW-1:0];
      hi_sel = cfg.ind8 ? p2_latch_i : dptr_i[2*BW-1:BW];
    end else begin
      lo_sel = pc_i[BW-1:0];
      hi_sel = pc_i[2*BW-1:BW];
    end
    unique case (stb.src)
      SRC_ADDR:  ad_nxt = lo_sel;
      SRC_WDATA: ad_nxt = wr_data_i;
      default:   ad_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_o     <= 1'b0;
      psen_no   <= 1'b1;
      rd_no     <= 1'b1;
      wr_no     <= 1'b1;
      ad_o      <= '0;
      ad_oe_o   <= 1'b0;
      addr_hi_o <= '0;
    end else begin
      ale_o     <= stb.ale;
      psen_no   <= stb.psen_n;
      rd_no     <= stb.rd_n;
      wr_no     <= stb.wr_n;
      ad_o      <= ad_nxt;
      ad_oe_o   <= (stb.src != SRC_NONE);
      addr_hi_o <= hi_sel;
    end
  end
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic psen_no,
  input logic rd_no,
  input logic wr_no,
  input logic ad_oe_o
);
  p_rd_wr_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_psen_vs_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!psen_no && (!rd_no || !wr_no)));

  p_bus_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (psen_no && rd_no));

  p_psen_after_ale_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_no) |-> (!ale_o && !$past(ale_o)));

  p_strobe_after_ale_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) || $fell(wr_no)) |-> (!ale_o && !$past(ale_o, 3)));

  p_wr_data_driven_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || $rose(wr_no)) |-> ad_oe_o);

  p_wr_min_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |=> !wr_no);
endmodule

bind xbus_strobe xbus_strobe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ale_o(ale_o), .psen_no(psen_no),
  .rd_no(rd_no), .wr_no(wr_no), .ad_oe_o(ad_oe_o)
);

// File: tb/xbus_strobe_tb.sv
module xbus_strobe_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_exec_i = 0, ale_dis_i = 0, xrd_req_i = 0, xwr_req_i = 0, code_rd_i = 0, ind8_i = 0;
  logic [15:0] pc_i = 0, dptr_i = 0;
  logic [7:0] ri_addr_i = 0, p2_latch_i = 0, wr_data_i = 0;
  logic ale_o, psen_no, rd_no, wr_no, ad_oe_o;
  logic [7:0] ad_o, addr_hi_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  xbus_strobe u_dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 fetch, 1 code, 2 read, 3 write
  task automatic run_cycle(bit ext, bit dis, bit rd, bit wr, bit code, bit i8,
                           logic [15:0] pc, logic [15:0] dp, logic [7:0] ri,
                           logic [7:0] p2, logic [7:0] wd, bit late_wr);
    int  kind;
    bit  data, fen, aen, act;
    int  e_ale, e_ps, e_rd, e_wr, e_oe, e_ad, e_hi;
    ext_exec_i = ext; ale_dis_i = dis; xrd_req_i = rd; xwr_req_i = wr;
    code_rd_i = code; ind8_i = i8; pc_i = pc; dptr_i = dp;
    ri_addr_i = ri; p2_latch_i = p2; wr_data_i = wd;
    kind = wr ? 3 : rd ? 2 : code ? 1 : 0;
    data = (kind >= 2);
    fen  = ext || kind == 1;
    aen  = !dis || ext || kind != 0;
    act  = fen || data;
    for (int p = 0; p < 12; p++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (late_wr && p == 2) xwr_req_i = 1'b1;
      e_ale = !aen || p < 2 || (!data && (p == 6 || p == 7));
      e_ps  = !(fen && !data && ((p >= 3 && p <= 5) || p >= 9));
      e_rd  = !(kind == 2 && p >= 5 && p <= 10);
      e_wr  = !(kind == 3 && p >= 5 && p <= 10);
      e_oe  = act && (p < 2 || (!data && (p == 6 || p == 7)) || (kind == 3 && p >= 3));
      e_ad  = (kind == 3 && p >= 3) ? wd : data ? (i8 ? ri : dp[7:0]) : pc[7:0];
      e_hi  = data ? (i8 ? p2 : dp[15:8]) : pc[15:8];
      chk(data ? "R3" : (dis ? (aen ? "R6" : "R5") : "R1"), "ale", ale_o, e_ale);
      chk("R2", "psen_n", psen_no, e_ps);
      chk(late_wr ? "R11" : "R4", "rd_n", rd_no, e_rd);
      chk(late_wr ? "R11" : "R4", "wr_n", wr_no, e_wr);
      chk("R8", "ad_oe", ad_oe_o, e_oe);
      if (e_oe) chk((kind == 3 && p >= 3) ? "R9" : "R8", "ad", ad_o, e_ad);
      chk("R7", "addr_hi", addr_hi_o, e_hi);
    end
    xwr_req_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10", "ale", ale_o, 0);
    chk("R10", "psen_n", psen_no, 1);
    chk("R10", "rd_n", rd_no, 1);
    chk("R10", "wr_n", wr_no, 1);
    chk("R10", "ad_oe", ad_oe_o, 0);
    chk("R10", "ad", ad_o, 0);
    chk("R10", "addr_hi", addr_hi_o, 0);
    rst_ni = 1'b1;
    // R10: first edge after release gives phase 0
    for (int m = 0; m < 80; m++) begin
      automatic int k = m % 40;
      automatic bit ext = k[0];
      automatic bit dis = k[1];
      automatic bit i8  = k[2];
      automatic int ty  = k / 8;   // 0 none,1 rd,2 wr,3 code,4 rd+wr
      run_cycle(ext, dis, ty == 1 || ty == 4, ty == 2 || ty == 4, ty == 3, i8,
                16'h1000 * m + 16'h0123 + m, 16'hA500 + 16'h0101 * m,
                8'h30 + m[7:0], 8'hC0 ^ m[7:0], 8'h5A + 8'(3 * m), 1'b0);
    end
    // R11: late write request ignored
    run_cycle(1, 0, 0, 0, 0, 0, 16'h7788, 16'h1122, 8'h44, 8'h55, 8'h66, 1'b1);
    run_cycle(0, 1, 1, 0, 0, 1, 16'h2468, 16'h1357, 8'h9A, 8'hBC, 8'hDE, 1'b1);
    // R10: reset mid-cycle
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10", "ale mid", ale_o, 0);
    chk("R10", "psen_n mid", psen_no, 1);
    chk("R10", "rd_n mid", rd_no, 1);
    chk("R10", "wr_n mid", wr_no, 1);
    chk("R10", "ad_oe mid", ad_oe_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_cycle(0, 0, 0, 1, 0, 0, 16'h0F0F, 16'hBEEF, 8'h01, 8'h02, 8'hA5, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule